// File: doc/BRIEF.md
# Conditional Branch Condition Evaluator

This block decides whether a conditional jump is taken. It receives the four arithmetic flags (carry, zero, sign, overflow) as one vector, a separate parity flag, a counter value and a 5-bit condition code. From these it produces a single take-branch bit. The supported predicates cover signed and unsigned comparisons, flag tests, parity and a counter-is-zero test. Several assembler mnemonics that mean the same thing (for example "equal" and "zero") share one code.

Codes 0 to 15 come in pairs. Bits [4:1] select a base predicate. Bit 0 set means the complement of that predicate. Code 16 tests whether the counter is zero. All other codes are never taken. The decision is captured in an output register, so `take_o` shows the inputs that were present at the previous rising clock edge.

Top module: `brcond_eval`

## Requirements
- R1: While `rst_i` is high at a rising edge, `take_o` is 0 after that edge.
- R2: `take_o` changes only at a rising edge. It equals the predicate of the code, flags, parity and count sampled at that edge.
- R3: Flag vector bit positions: [0] carry, [1] zero, [2] sign, [3] overflow. Code 0 is taken when overflow=1. Code 1 is taken when overflow=0.
- R4: Code 2 is taken when sign=1. Code 3 is taken when sign=0.
- R5: Code 4 (equal/zero) is taken when zero=1. Code 5 is taken when zero=0.
- R6: Code 6 (below/carry) is taken when carry=1. Code 7 (above-or-equal) is taken when carry=0.
- R7: Code 8 (below-or-equal) is taken when carry=1 or zero=1. Code 9 (above) is taken when carry=0 and zero=0.
- R8: Code 10 (less) is taken when sign differs from overflow. Code 11 (greater-or-equal) is taken when they are equal.
- R9: Code 12 (less-or-equal) is taken when zero=1 or sign differs from overflow. Code 13 (greater) is taken when zero=0 and sign equals overflow.
- R10: Code 14 (parity even) is taken when `parity_i`=1. Code 15 (parity odd) is taken when `parity_i`=0.
- R11: Code 16 is taken exactly when every bit of `count_i` is 0. The flags and parity have no effect on it.
- R12: Codes 17 to 31 are never taken, whatever the flags, parity and count are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| code_i | input | 5 | Condition code |
| flags_i | input | 4 | {overflow, sign, zero, carry} |
| parity_i | input | 1 | Parity flag |
| count_i | input | CNT_W | Counter value for the zero test |
| take_o | output | 1 | Registered take-branch decision |

## Verification
The bench builds the block with `CNT_W` set to 4 instead of the default 32. With 4 bits, the single-bit counts, the all-ones count and a count whose only set bit is the top bit can be reached in a few vectors, so every bit of the zero-detect chain is exercised. Every code from 0 to 31 is then swept against all sixteen flag combinations and both parity values, with several counts. This covers every base predicate, every inverted partner and every unused code.

// File: rtl/brcond_pkg.sv
package brcond_pkg;

    localparam int CODE_W   = 5;
    localparam int FLAG_W   = 4;
    localparam int NUM_BASE = 8;
    localparam int SEL_W    = CODE_W - 1;

    // base predicate indices (code[4:1])
    localparam logic [SEL_W-1:0] BASE_OVF  = 4'd0;
    localparam logic [SEL_W-1:0] BASE_SIGN = 4'd1;
    localparam logic [SEL_W-1:0] BASE_ZERO = 4'd2;
    localparam logic [SEL_W-1:0] BASE_CRY  = 4'd3;
    localparam logic [SEL_W-1:0] BASE_BEQ  = 4'd4;
    localparam logic [SEL_W-1:0] BASE_LT   = 4'd5;
    localparam logic [SEL_W-1:0] BASE_LE   = 4'd6;
    localparam logic [SEL_W-1:0] BASE_PAR  = 4'd7;
    localparam logic [SEL_W-1:0] BASE_CNT  = 4'd8;

    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic cry;
    } flags_t;

    typedef struct packed {
        logic [SEL_W-1:0] base;
        logic             inv;
    } cond_t;

    function automatic cond_t split_code(input logic [CODE_W-1:0] c);
        cond_t r;
        r.base = c[CODE_W-1:1];
        r.inv  = c[0];
        return r;
    endfunction

    function automatic logic signed_lt(input flags_t f);
        return f.sgn ^ f.ovf;
    endfunction

endpackage

// File: rtl/brcond_base_eval.sv
module brcond_base_eval
    import brcond_pkg::*;
(
    input  flags_t              flags_i,
    input  logic                parity_i,
    output logic [NUM_BASE-1:0] base_o
);
    logic lt;

    always_comb begin
        lt = signed_lt(flags_i);
        base_o           = '0;
        base_o[BASE_OVF]  = flags_i.ovf;
        base_o[BASE_SIGN] = flags_i.sgn;
        base_o[BASE_ZERO] = flags_i.zro;
        base_o[BASE_CRY]  = flags_i.cry;
        base_o[BASE_BEQ]  = flags_i.cry | flags_i.zro;
        base_o[BASE_LT]   = lt;
        base_o[BASE_LE]   = flags_i.zro | lt;
        base_o[BASE_PAR]  = parity_i;
    end
endmodule

// File: rtl/brcond_cnt_zero.sv
module brcond_cnt_zero #(
    parameter int CNT_W = 32
) (
    input  logic [CNT_W-1:0] count_i,
    output logic             zero_o
);
    logic [CNT_W:0] any_set;
    assign any_set[0] = 1'b0;

    for (genvar i = 0; i < CNT_W; i++) begin : g_chain
        assign any_set[i+1] = any_set[i] | count_i[i];
    end

    assign zero_o = ~any_set[CNT_W];
endmodule

// File: rtl/brcond_select.sv
module brcond_select
    import brcond_pkg::*;
(
    input  logic [CODE_W-1:0]   code_i,
    input  logic [NUM_BASE-1:0] base_i,
    input  logic                cnt_zero_i,
    output logic                take_o
);
    cond_t c;

    always_comb begin
        c = split_code(code_i);
        if (c.base < SEL_W'(NUM_BASE)) begin
            take_o = base_i[c.base[2:0]] ^ c.inv;
        end else if (c.base == BASE_CNT && !c.inv) begin
            take_o = cnt_zero_i;
        end else begin
            take_o = 1'b0;
        end
    end
endmodule

// File: rtl/brcond_eval.sv
module brcond_eval
    import brcond_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [4:0]        code_i,
    input  logic [3:0]        flags_i,
    input  logic              parity_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic              take_o
);
    logic [NUM_BASE-1:0] base_vec;
    logic                cnt_zero;
    logic                take_d;

    brcond_base_eval u_base (
        .flags_i  (flags_t'(flags_i)),
        .parity_i (parity_i),
        .base_o   (base_vec)
    );

    brcond_cnt_zero #(.CNT_W(CNT_W)) u_cz (
        .count_i (count_i),
        .zero_o  (cnt_zero)
    );

    brcond_select u_sel (
        .code_i     (code_i),
        .base_i     (base_vec),
        .cnt_zero_i (cnt_zero),
        .take_o     (take_d)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) take_o <= 1'b0;
        else       take_o <= take_d;
    end
endmodule

// File: rtl/brcond_eval_chk.sv
module brcond_eval_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic [4:0]       code_i,
    input logic [3:0]       flags_i,
    input logic             parity_i,
    input logic [CNT_W-1:0] count_i,
    input logic             take_o
);
    assert_reset_clear_R1: assert property (@(posedge clk_i)
        rst_i |=> !take_o);

    assert_zero_pair_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (code_i == 5'd4) |=> (take_o == $past(flags_i[1])));

    assert_below_eq_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (code_i == 5'd8) |=> (take_o == $past(flags_i[0] | flags_i[1])));

    assert_less_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (code_i == 5'd10) |=> (take_o == $past(flags_i[2] ^ flags_i[3])));

    assert_parity_odd_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        (code_i == 5'd15) |=> (take_o == $past(!parity_i)));

    assert_counter_zero_R11: assert property (@(posedge clk_i) disable iff (rst_i)
        (code_i == 5'd16) |=> (take_o == ($past(count_i) == '0)));

    assert_unused_code_R12: assert property (@(posedge clk_i) disable iff (rst_i)
        (code_i > 5'd16) |=> !take_o);
endmodule

bind brcond_eval brcond_eval_chk #(.CNT_W(CNT_W)) chk_i (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .code_i   (code_i),
    .flags_i  (flags_i),
    .parity_i (parity_i),
    .count_i  (count_i),
    .take_o   (take_o)
);

// File: tb/brcond_eval_tb_top.sv
module brcond_eval_tb_top;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic [4:0]    code;
    logic [3:0]    flags;
    logic          par;
    logic [CW-1:0] cnt;
    logic          take;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    brcond_eval #(.CNT_W(CW)) dut_i (
        .clk_i(clk), .rst_i(rst), .code_i(code), .flags_i(flags),
        .parity_i(par), .count_i(cnt), .take_o(take)
    );

    // {code[14:10], flags[9:6], parity[5], count[4:1], expected[0]}
    localparam int NV = 16;
    localparam logic [14:0] VEC [NV] = '{
        {5'd16, 4'b0000, 1'b0, 4'b0000, 1'b1},
        {5'd16, 4'b1111, 1'b1, 4'b0000, 1'b1},
        {5'd16, 4'b1111, 1'b1, 4'b0001, 1'b0},
        {5'd16, 4'b0000, 1'b0, 4'b1000, 1'b0},
        {5'd16, 4'b0000, 1'b0, 4'b1111, 1'b0},
        {5'd16, 4'b0000, 1'b0, 4'b0100, 1'b0},
        {5'd17, 4'b0000, 1'b0, 4'b0000, 1'b0},
        {5'd31, 4'b1111, 1'b1, 4'b0000, 1'b0},
        {5'd9,  4'b0000, 1'b0, 4'b0000, 1'b1},
        {5'd9,  4'b0010, 1'b0, 4'b0000, 1'b0},
        {5'd13, 4'b1100, 1'b0, 4'b0000, 1'b1},
        {5'd13, 4'b1110, 1'b0, 4'b0000, 1'b0},
        {5'd12, 4'b0100, 1'b0, 4'b0000, 1'b1},
        {5'd11, 4'b1000, 1'b0, 4'b0000, 1'b0},
        {5'd14, 4'b0000, 1'b1, 4'b0000, 1'b1},
        {5'd0,  4'b1000, 1'b0, 4'b0000, 1'b1}
    };

    function automatic logic model(input logic [4:0] c, input logic [3:0] f,
                                   input logic p, input logic [CW-1:0] n);
        logic cf, zf, sf, of, b;
        cf = f[0]; zf = f[1]; sf = f[2]; of = f[3];
        case (c[4:1])
            4'd0: b = of;
            4'd1: b = sf;
            4'd2: b = zf;
            4'd3: b = cf;
            4'd4: b = cf || zf;
            4'd5: b = (sf != of);
            4'd6: b = zf || (sf != of);
            4'd7: b = p;
            default: b = 1'b0;
        endcase
        if (c < 5'd16) return b ^ c[0];
        if (c == 5'd16) return (n == 0);
        return 1'b0;
    endfunction

    function automatic string tag(input logic [4:0] c);
        case (c[4:1])
            4'd0: return "R3";
            4'd1: return "R4";
            4'd2: return "R5";
            4'd3: return "R6";
            4'd4: return "R7";
            4'd5: return "R8";
            4'd6: return "R9";
            4'd7: return "R10";
            default: return (c == 5'd16) ? "R11" : "R12";
        endcase
    endfunction

    task automatic check(input string req, input logic exp);
        checks++;
        if (take !== exp) begin
            errors++;
            $display("FAIL %s code=%0d flags=%b par=%b cnt=%h: actual=%b expected=%b",
                     req, code, flags, par, cnt, take, exp);
        end
    endtask

    // drive on falling edge, sample shortly after next rising edge (R2 latency)
    task automatic apply(input logic [4:0] c, input logic [3:0] f,
                         input logic p, input logic [CW-1:0] n);
        @(negedge clk);
        code = c; flags = f; par = p; cnt = n;
        @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; code = 5'd4; flags = 4'b0010; par = 1'b0; cnt = '0;
        repeat (3) @(posedge clk);
        #2;
        check("R1", 1'b0);   // reset holds output low despite a taken condition
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #2;
        check("R2", 1'b1);   // first edge after reset shows code 4 with zero=1

        // R2: output holds its value until the next edge
        apply(5'd5, 4'b0010, 1'b0, '0);
        check("R5", 1'b0);
        @(negedge clk);
        code = 5'd4;
        #3;
        check("R2", 1'b0);   // input changed mid-cycle, output unchanged

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][14:10], VEC[i][9:6], VEC[i][5], VEC[i][4:1]);
            check(tag(VEC[i][14:10]), VEC[i][0]);
        end

        for (int c = 0; c < 32; c++) begin
            for (int f = 0; f < 16; f++) begin
                for (int p = 0; p < 2; p++) begin
                    logic [CW-1:0] n;
                    n = CW'((f + p) % 3 == 0 ? 0 : (f ^ c));
                    apply(5'(c), 4'(f), 1'(p), n);
                    check(tag(5'(c)), model(5'(c), 4'(f), 1'(p), n));
                end
            end
        end

        // R1: reset asserted mid-run clears a taken output
        apply(5'd16, 4'b0000, 1'b0, '0);
        check("R11", 1'b1);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #2;
        check("R1", 1'b0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule